// File: doc/BRIEF.md
# Banked Dual-Port Byte Memory with Semaphore Tokens

This block is a byte-wide memory with two fully independent ports, left and right. Each port has its own address, write data, read data, a write select, an output enable, an active-low memory select and an active-low token select. The storage is split into equal banks. On each port the three address bits above the in-bank word address pick one bank through that port's own decoder. The bits below them pick a word inside that bank. A parameter builds either the full bank count (eight) or half of it (four). In the half build the topmost address bit is treated as zero.

A port's select pair steers each access. With the memory select low and the token select high, the access goes to the banks. With the token select low and the memory select high, it goes to a small space of eight one-bit ownership tokens that the two ports use to hand resources back and forth. Both ports are sampled on the same rising clock edge. A write takes effect at that edge, and read data comes out one cycle later together with a valid flag. The tri-state data pins are modelled as separate input and output buses.

Top module: `banked_dpram`

## Requirements
- R1: After reset, both ports' valid flags are low, both read buses are zero, and all eight tokens are free.
- R2: A byte written by one port at an address appears, on a later read of that address from either port, on the read bus one cycle after the read is sampled, with the valid flag high.
- R3: Address bits [BANK_AW+2:BANK_AW] pick the bank and the bits below them pick the word. Addresses that differ only in the bank field hold independent bytes.
- R4: With HALF_CFG=1 only four banks exist. Address bit BANK_AW+2 is ignored, so addresses that differ only in that bit name the same byte.
- R5: The valid flag of a port rises one cycle after a sampled access that has exactly one of its two selects low, the output enable high and the write select low. It is low after any other access.
- R6: An access with both selects low on a port is ignored. It writes no memory, changes no token and gives no read data.
- R7: While a port's valid flag is low, its read bus is all zeros.
- R8: When both ports write the same memory address on the same edge, the left port's byte is stored.
- R9: A token access uses address bits [2:0] as the token number. Writing data bit 0 = 0 requests the token, and the request is granted only if the other port does not hold it. Reading the token returns 8'h00 if the reading port holds it and 8'hFF otherwise.
- R10: Writing data bit 0 = 1 to a token releases it, after which the other port can be granted it.
- R11: The eight tokens are independent. Each port may hold different tokens at the same time.
- R12: When both ports request the same free token on the same edge, the left port is granted it and the right port is not.
- R13: A token is never held by both ports at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock; both ports sample on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset of flags and tokens |
| l_addr | input | BANK_AW+3 | Left port address |
| l_wdata | input | DW | Left port write data |
| l_wr | input | 1 | Left port write select (1 = write, 0 = read) |
| l_oe | input | 1 | Left port output enable |
| l_cs_n | input | 1 | Left port memory select, active low |
| l_sem_n | input | 1 | Left port token select, active low |
| l_rdata | output | DW | Left port read data |
| l_rvalid | output | 1 | Left port read data valid |
| r_addr | input | BANK_AW+3 | Right port address |
| r_wdata | input | DW | Right port write data |
| r_wr | input | 1 | Right port write select (1 = write, 0 = read) |
| r_oe | input | 1 | Right port output enable |
| r_cs_n | input | 1 | Right port memory select, active low |
| r_sem_n | input | 1 | Right port token select, active low |
| r_rdata | output | DW | Right port read data |
| r_rvalid | output | 1 | Right port read data valid |

## Verification
The properties assume that inputs are stable and known around each rising edge and that reset lasts at least one edge. They accept any mix of selects, including the illegal case where both are low. The release and tie-break properties assume that the token number comes from address bits [2:0] and the request/release choice from data bit 0. The stimulus changes inputs only on falling edges and keeps every port idle with both selects high whenever it is not performing a listed access. It reads only addresses it has written earlier, because memory contents have no reset value.

// File: rtl/bdp_pkg.sv
package bdp_pkg;
   // kind of access a port performs in one cycle
   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_RAM  = 2'd1,
      ACC_SEM  = 2'd2
   } acc_e;

   localparam int unsigned BSEL_W = 3;  // width of the bank field in the address
   localparam int unsigned NTOK   = 8;  // number of semaphore tokens
   localparam int unsigned TOK_W  = 3;  // width of the token number
endpackage

// File: rtl/bdp_port_decode.sv
module bdp_port_decode
   import bdp_pkg::*;
#(
   parameter int unsigned NB       = 8,
   parameter bit          HALF_CFG = 1'b0
) (
   input  logic [BSEL_W-1:0] bsel,
   input  logic              cs_n,
   input  logic              sem_n,
   input  logic              wr,
   input  logic              oe,
   output logic [NB-1:0]     bank_oh,
   output logic              ram_wr,
   output logic              sem_wr,
   output logic              rd_req,
   output logic              is_sem
);
   acc_e              acc;
   logic [BSEL_W-1:0] bidx;

   always_comb begin
      if (!cs_n && sem_n)      acc = ACC_RAM;
      else if (cs_n && !sem_n) acc = ACC_SEM;
      else                     acc = ACC_NONE;
   end

   generate
      if (HALF_CFG) begin : g_half
         // the topmost bank bit is treated as tied low
         assign bidx = {1'b0, bsel[BSEL_W-2:0]};
      end else begin : g_full
         assign bidx = bsel;
      end
   endgenerate

   generate
      for (genvar b = 0; b < NB; b++) begin : g_oh
         assign bank_oh[b] = (acc == ACC_RAM) && (bidx == BSEL_W'(b));
      end
   endgenerate

   assign ram_wr = (acc == ACC_RAM) && wr;
   assign sem_wr = (acc == ACC_SEM) && wr;
   assign rd_req = (acc != ACC_NONE) && oe && !wr;
   assign is_sem = (acc == ACC_SEM);
endmodule

// File: rtl/bdp_bank.sv
module bdp_bank #(
   parameter int unsigned DW  = 8,
   parameter int unsigned AWB = 8
) (
   input  logic           clk,
   input  logic           l_we,
   input  logic [AWB-1:0] l_addr,
   input  logic [DW-1:0]  l_wdata,
   input  logic           r_we,
   input  logic [AWB-1:0] r_addr,
   input  logic [DW-1:0]  r_wdata,
   output logic [DW-1:0]  l_q,
   output logic [DW-1:0]  r_q
);
   localparam int unsigned DEPTH = 1 << AWB;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      // right first, so a left write to the same word overrides it
      if (r_we) mem[r_addr] <= r_wdata;
      if (l_we) mem[l_addr] <= l_wdata;
      l_q <= mem[l_addr];
      r_q <= mem[r_addr];
   end
endmodule

// File: rtl/bdp_sem.sv
module bdp_sem
   import bdp_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             l_wr,
   input  logic [TOK_W-1:0] l_idx,
   input  logic             l_bit,
   input  logic             r_wr,
   input  logic [TOK_W-1:0] r_idx,
   input  logic             r_bit,
   output logic [NTOK-1:0]  l_hold,
   output logic [NTOK-1:0]  r_hold
);
   generate
      for (genvar t = 0; t < NTOK; t++) begin : g_tok
         logic l_req, l_rel, r_req, r_rel, l_gnt, r_gnt;
         assign l_req = l_wr && (l_idx == TOK_W'(t)) && !l_bit;
         assign l_rel = l_wr && (l_idx == TOK_W'(t)) &&  l_bit;
         assign r_req = r_wr && (r_idx == TOK_W'(t)) && !r_bit;
         assign r_rel = r_wr && (r_idx == TOK_W'(t)) &&  r_bit;
         // left has priority on a tie for a free token
         assign l_gnt = l_req && !r_hold[t];
         assign r_gnt = r_req && !l_hold[t] && !l_gnt;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               l_hold[t] <= 1'b0;
               r_hold[t] <= 1'b0;
            end else begin
               if (l_rel)      l_hold[t] <= 1'b0;
               else if (l_gnt) l_hold[t] <= 1'b1;
               if (r_rel)      r_hold[t] <= 1'b0;
               else if (r_gnt) r_hold[t] <= 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/bdp_rdpath.sv
module bdp_rdpath #(
   parameter int unsigned DW = 8,
   parameter int unsigned NB = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_req,
   input  logic             is_sem,
   input  logic [NB-1:0]    bank_oh,
   input  logic             own_tok,
   input  logic [NB*DW-1:0] bank_q,
   output logic [DW-1:0]    rdata,
   output logic             rvalid
);
   logic          rv_q, sem_q, own_q;
   logic [NB-1:0] oh_q;
   logic [DW-1:0] ram_v;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rv_q  <= 1'b0;
         sem_q <= 1'b0;
         own_q <= 1'b0;
         oh_q  <= '0;
      end else begin
         rv_q  <= rd_req;
         sem_q <= is_sem;
         own_q <= own_tok;
         oh_q  <= bank_oh;
      end
   end

   always_comb begin
      ram_v = '0;
      for (int b = 0; b < NB; b++) begin
         if (oh_q[b]) ram_v = ram_v | bank_q[b*DW +: DW];
      end
   end

   always_comb begin
      if (!rv_q)     rdata = '0;
      else if (sem_q) rdata = {DW{!own_q}};
      else           rdata = ram_v;
   end

   assign rvalid = rv_q;
endmodule

// File: rtl/banked_dpram.sv
module banked_dpram
   import bdp_pkg::*;
#(
   parameter int unsigned DW       = 8,
   parameter int unsigned BANK_AW  = 8,
   parameter bit          HALF_CFG = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [BANK_AW+2:0]    l_addr,
   input  logic [DW-1:0]         l_wdata,
   input  logic                  l_wr,
   input  logic                  l_oe,
   input  logic                  l_cs_n,
   input  logic                  l_sem_n,
   output logic [DW-1:0]         l_rdata,
   output logic                  l_rvalid,
   input  logic [BANK_AW+2:0]    r_addr,
   input  logic [DW-1:0]         r_wdata,
   input  logic                  r_wr,
   input  logic                  r_oe,
   input  logic                  r_cs_n,
   input  logic                  r_sem_n,
   output logic [DW-1:0]         r_rdata,
   output logic                  r_rvalid
);
   localparam int unsigned NB_FULL = 1 << BSEL_W;
   localparam int unsigned NB      = HALF_CFG ? NB_FULL / 2 : NB_FULL;
   localparam int unsigned AW      = BANK_AW + BSEL_W;

   generate
      if (DW < 1) begin : g_bad_dw
         $error("banked_dpram: DW must be at least 1");
      end
      if (BANK_AW < TOK_W) begin : g_bad_aw
         $error("banked_dpram: BANK_AW must cover the token number");
      end
   endgenerate

   logic [NB-1:0]    l_oh, r_oh;
   logic             l_ram_wr, r_ram_wr, l_sem_wr, r_sem_wr;
   logic             l_rd, r_rd, l_is_sem, r_is_sem;
   logic [NTOK-1:0]  l_hold, r_hold;
   logic [NB*DW-1:0] l_q_flat, r_q_flat;

   bdp_port_decode #(.NB(NB), .HALF_CFG(HALF_CFG)) u_dec_l (
      .bsel(l_addr[AW-1 -: BSEL_W]), .cs_n(l_cs_n), .sem_n(l_sem_n),
      .wr(l_wr), .oe(l_oe), .bank_oh(l_oh), .ram_wr(l_ram_wr),
      .sem_wr(l_sem_wr), .rd_req(l_rd), .is_sem(l_is_sem));

   bdp_port_decode #(.NB(NB), .HALF_CFG(HALF_CFG)) u_dec_r (
      .bsel(r_addr[AW-1 -: BSEL_W]), .cs_n(r_cs_n), .sem_n(r_sem_n),
      .wr(r_wr), .oe(r_oe), .bank_oh(r_oh), .ram_wr(r_ram_wr),
      .sem_wr(r_sem_wr), .rd_req(r_rd), .is_sem(r_is_sem));

   generate
      for (genvar b = 0; b < NB; b++) begin : g_bank
         bdp_bank #(.DW(DW), .AWB(BANK_AW)) u_bank (
            .clk(clk),
            .l_we(l_oh[b] && l_ram_wr), .l_addr(l_addr[BANK_AW-1:0]),
            .l_wdata(l_wdata),
            .r_we(r_oh[b] && r_ram_wr), .r_addr(r_addr[BANK_AW-1:0]),
            .r_wdata(r_wdata),
            .l_q(l_q_flat[b*DW +: DW]), .r_q(r_q_flat[b*DW +: DW]));
      end
   endgenerate

   bdp_sem u_sem (
      .clk(clk), .rst_n(rst_n),
      .l_wr(l_sem_wr), .l_idx(l_addr[TOK_W-1:0]), .l_bit(l_wdata[0]),
      .r_wr(r_sem_wr), .r_idx(r_addr[TOK_W-1:0]), .r_bit(r_wdata[0]),
      .l_hold(l_hold), .r_hold(r_hold));

   bdp_rdpath #(.DW(DW), .NB(NB)) u_rd_l (
      .clk(clk), .rst_n(rst_n), .rd_req(l_rd), .is_sem(l_is_sem),
      .bank_oh(l_oh), .own_tok(l_hold[l_addr[TOK_W-1:0]]),
      .bank_q(l_q_flat), .rdata(l_rdata), .rvalid(l_rvalid));

   bdp_rdpath #(.DW(DW), .NB(NB)) u_rd_r (
      .clk(clk), .rst_n(rst_n), .rd_req(r_rd), .is_sem(r_is_sem),
      .bank_oh(r_oh), .own_tok(r_hold[r_addr[TOK_W-1:0]]),
      .bank_q(r_q_flat), .rdata(r_rdata), .rvalid(r_rvalid));
endmodule

// File: rtl/banked_dpram_chk.sv
module banked_dpram_chk
   import bdp_pkg::*;
#(
   parameter int unsigned DW = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             l_cs_n, l_sem_n, l_wr, l_oe, l_wbit,
   input logic [TOK_W-1:0] l_tidx,
   input logic             r_cs_n, r_sem_n, r_wr, r_oe, r_wbit,
   input logic [TOK_W-1:0] r_tidx,
   input logic [DW-1:0]    l_rdata, r_rdata,
   input logic             l_rvalid, r_rvalid,
   input logic [NTOK-1:0]  l_hold, r_hold
);
   // R5: valid only after a selected, enabled read
   a_r5_l_valid_src: assert property (@(posedge clk) disable iff (!rst_n)
      l_rvalid |-> $past((l_cs_n != l_sem_n) && l_oe && !l_wr));
   a_r5_r_valid_src: assert property (@(posedge clk) disable iff (!rst_n)
      r_rvalid |-> $past((r_cs_n != r_sem_n) && r_oe && !r_wr));
   // R7: quiet bus when not valid
   a_r7_l_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !l_rvalid |-> (l_rdata == '0));
   a_r7_r_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !r_rvalid |-> (r_rdata == '0));
   // R6: both selects low changes nothing on that port
   a_r6_l_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      (!l_cs_n && !l_sem_n) |=> (!l_rvalid && $stable(l_hold)));
   a_r6_r_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      (!r_cs_n && !r_sem_n) |=> (!r_rvalid && $stable(r_hold)));
   // R13: exclusive ownership
   a_r13_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(l_hold & r_hold)));
   // R10: release takes effect
   a_r10_l_release: assert property (@(posedge clk) disable iff (!rst_n)
      (l_cs_n && !l_sem_n && l_wr && l_wbit) |=> !l_hold[$past(l_tidx)]);
   a_r10_r_release: assert property (@(posedge clk) disable iff (!rst_n)
      (r_cs_n && !r_sem_n && r_wr && r_wbit) |=> !r_hold[$past(r_tidx)]);
   // R12: left wins a tie for a free token
   a_r12_tie: assert property (@(posedge clk) disable iff (!rst_n)
      (l_cs_n && !l_sem_n && l_wr && !l_wbit &&
       r_cs_n && !r_sem_n && r_wr && !r_wbit &&
       (l_tidx == r_tidx) && !l_hold[l_tidx] && !r_hold[r_tidx])
      |=> (l_hold[$past(l_tidx)] && !r_hold[$past(r_tidx)]));
endmodule

bind banked_dpram banked_dpram_chk #(.DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .l_cs_n(l_cs_n), .l_sem_n(l_sem_n), .l_wr(l_wr), .l_oe(l_oe),
   .l_wbit(l_wdata[0]), .l_tidx(l_addr[2:0]),
   .r_cs_n(r_cs_n), .r_sem_n(r_sem_n), .r_wr(r_wr), .r_oe(r_oe),
   .r_wbit(r_wdata[0]), .r_tidx(r_addr[2:0]),
   .l_rdata(l_rdata), .r_rdata(r_rdata),
   .l_rvalid(l_rvalid), .r_rvalid(r_rvalid),
   .l_hold(l_hold), .r_hold(r_hold));

// File: tb/banked_dpram_bench.sv
`timescale 1ns/1ps
module banked_dpram_bench;
   localparam int AW = 11;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [AW-1:0] l_addr, r_addr, h_addr;
   logic [7:0]    l_wdata, r_wdata, h_wdata, l_rdata, r_rdata, h_rdata, h_rd_r;
   logic          l_wr, l_oe, l_cs_n, l_sem_n, l_rvalid;
   logic          r_wr, r_oe, r_cs_n, r_sem_n, r_rvalid;
   logic          h_wr, h_oe, h_cs_n, h_sem_n, h_rvalid, h_rv_r;

   banked_dpram u_banked_dpram (
      .clk(clk), .rst_n(rst_n),
      .l_addr(l_addr), .l_wdata(l_wdata), .l_wr(l_wr), .l_oe(l_oe),
      .l_cs_n(l_cs_n), .l_sem_n(l_sem_n), .l_rdata(l_rdata), .l_rvalid(l_rvalid),
      .r_addr(r_addr), .r_wdata(r_wdata), .r_wr(r_wr), .r_oe(r_oe),
      .r_cs_n(r_cs_n), .r_sem_n(r_sem_n), .r_rdata(r_rdata), .r_rvalid(r_rvalid));

   banked_dpram #(.HALF_CFG(1'b1)) u_half (
      .clk(clk), .rst_n(rst_n),
      .l_addr(h_addr), .l_wdata(h_wdata), .l_wr(h_wr), .l_oe(h_oe),
      .l_cs_n(h_cs_n), .l_sem_n(h_sem_n), .l_rdata(h_rdata), .l_rvalid(h_rvalid),
      .r_addr('0), .r_wdata('0), .r_wr(1'b0), .r_oe(1'b0),
      .r_cs_n(1'b1), .r_sem_n(1'b1), .r_rdata(h_rd_r), .r_rvalid(h_rv_r));

   typedef struct packed {
      logic          cs_n, sem_n, wr, oe;
      logic [AW-1:0] addr;
      logic [7:0]    wd;
      logic          ev;
      logic [7:0]    ed;
   } vec_t;

   // left-port vectors, right port idle; result is checked one edge later
   localparam vec_t VT [0:9] = '{
      '{1'b0, 1'b1, 1'b1, 1'b0, 11'h005, 8'hA1, 1'b0, 8'h00}, // R3 bank 0 write
      '{1'b0, 1'b1, 1'b1, 1'b0, 11'h705, 8'hB7, 1'b0, 8'h00}, // R3 bank 7 write
      '{1'b0, 1'b1, 1'b1, 1'b1, 11'h305, 8'hC3, 1'b0, 8'h00}, // R5 write with oe high
      '{1'b0, 1'b1, 1'b0, 1'b1, 11'h005, 8'h00, 1'b1, 8'hA1}, // R2 read back
      '{1'b0, 1'b1, 1'b0, 1'b1, 11'h705, 8'h00, 1'b1, 8'hB7}, // R3 bank 7 independent
      '{1'b0, 1'b1, 1'b0, 1'b1, 11'h305, 8'h00, 1'b1, 8'hC3}, // R3 bank 3
      '{1'b0, 1'b1, 1'b0, 1'b0, 11'h005, 8'h00, 1'b0, 8'h00}, // R7 oe low
      '{1'b1, 1'b1, 1'b0, 1'b1, 11'h005, 8'h00, 1'b0, 8'h00}, // R5 deselected
      '{1'b0, 1'b0, 1'b1, 1'b1, 11'h005, 8'hFF, 1'b0, 8'h00}, // R6 both selects low
      '{1'b0, 1'b1, 1'b0, 1'b1, 11'h005, 8'h00, 1'b1, 8'hA1}  // R6 byte unchanged
   };

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic lset(input logic cs_n, sem_n, wr, oe, input logic [AW-1:0] a, input logic [7:0] d);
      l_cs_n = cs_n; l_sem_n = sem_n; l_wr = wr; l_oe = oe; l_addr = a; l_wdata = d;
   endtask
   task automatic rset(input logic cs_n, sem_n, wr, oe, input logic [AW-1:0] a, input logic [7:0] d);
      r_cs_n = cs_n; r_sem_n = sem_n; r_wr = wr; r_oe = oe; r_addr = a; r_wdata = d;
   endtask
   task automatic hset(input logic cs_n, sem_n, wr, oe, input logic [AW-1:0] a, input logic [7:0] d);
      h_cs_n = cs_n; h_sem_n = sem_n; h_wr = wr; h_oe = oe; h_addr = a; h_wdata = d;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  %0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      lset(1, 1, 0, 0, '0, '0);
      rset(1, 1, 0, 0, '0, '0);
      hset(1, 1, 0, 0, '0, '0);
      repeat (3) @(negedge clk);
      chk("R1 l_rvalid", {7'd0, l_rvalid}, 8'h00);
      chk("R1 l_rdata", l_rdata, 8'h00);
      chk("R1 r_rvalid", {7'd0, r_rvalid}, 8'h00);
      chk("R1 r_rdata", r_rdata, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 tokens free: token reads give 8'hFF
      lset(1, 0, 0, 1, 11'h000, 8'h00);
      rset(1, 0, 0, 1, 11'h007, 8'h00);
      @(negedge clk);
      chk("R1 l token free", l_rdata, 8'hFF);
      chk("R1 r token free", r_rdata, 8'hFF);
      rset(1, 1, 0, 0, '0, '0);

      for (int i = 0; i < 10; i++) begin
         lset(VT[i].cs_n, VT[i].sem_n, VT[i].wr, VT[i].oe, VT[i].addr, VT[i].wd);
         @(negedge clk);
         chk($sformatf("R5 vec%0d valid", i), {7'd0, l_rvalid}, {7'd0, VT[i].ev});
         chk($sformatf("R2/R3 vec%0d data", i), l_rdata, VT[i].ed);
      end

      // R2 cross-port visibility
      lset(0, 1, 1, 0, 11'h210, 8'h5A);
      @(negedge clk);
      lset(1, 1, 0, 0, '0, '0);
      rset(0, 1, 0, 1, 11'h210, 8'h00);
      @(negedge clk);
      chk("R2 right sees left write", r_rdata, 8'h5A);
      chk("R2 right valid", {7'd0, r_rvalid}, 8'h01);

      // R8 same-address collision
      lset(0, 1, 1, 0, 11'h422, 8'h11);
      rset(0, 1, 1, 0, 11'h422, 8'h22);
      @(negedge clk);
      lset(0, 1, 0, 1, 11'h422, 8'h00);
      rset(0, 1, 0, 1, 11'h422, 8'h00);
      @(negedge clk);
      chk("R8 left wins (left read)", l_rdata, 8'h11);
      chk("R8 left wins (right read)", r_rdata, 8'h11);

      // R9 request token 2 by left, then right is refused
      lset(1, 0, 1, 0, 11'h002, 8'h00);
      rset(1, 1, 0, 0, '0, '0);
      @(negedge clk);
      lset(1, 1, 0, 0, '0, '0);
      rset(1, 0, 1, 0, 11'h002, 8'h00);
      @(negedge clk);
      lset(1, 0, 0, 1, 11'h002, 8'h00);
      rset(1, 0, 0, 1, 11'h002, 8'h00);
      @(negedge clk);
      chk("R9 left holds token 2", l_rdata, 8'h00);
      chk("R9 right refused token 2", r_rdata, 8'hFF);

      // R11 right takes token 3 while left keeps token 2
      lset(1, 1, 0, 0, '0, '0);
      rset(1, 0, 1, 0, 11'h003, 8'h00);
      @(negedge clk);
      lset(1, 0, 0, 1, 11'h003, 8'h00);
      rset(1, 0, 0, 1, 11'h003, 8'h00);
      @(negedge clk);
      chk("R11 left sees token 3 not own", l_rdata, 8'hFF);
      chk("R11 right holds token 3", r_rdata, 8'h00);

      // R10 left releases token 2, right then gets it
      lset(1, 0, 1, 0, 11'h002, 8'h01);
      rset(1, 1, 0, 0, '0, '0);
      @(negedge clk);
      lset(1, 1, 0, 0, '0, '0);
      rset(1, 0, 1, 0, 11'h002, 8'h00);
      @(negedge clk);
      lset(1, 0, 0, 1, 11'h002, 8'h00);
      rset(1, 0, 0, 1, 11'h002, 8'h00);
      @(negedge clk);
      chk("R10 left released token 2", l_rdata, 8'hFF);
      chk("R10 right granted token 2", r_rdata, 8'h00);

      // R12 tie on free token 5
      lset(1, 0, 1, 0, 11'h005, 8'h00);
      rset(1, 0, 1, 0, 11'h005, 8'h00);
      @(negedge clk);
      lset(1, 0, 0, 1, 11'h005, 8'h00);
      rset(1, 0, 0, 1, 11'h005, 8'h00);
      @(negedge clk);
      chk("R12 left wins tie", l_rdata, 8'h00);
      chk("R12 right loses tie", r_rdata, 8'hFF);

      // R6 both selects low on right: release attempt of token 3 ignored
      lset(1, 1, 0, 0, '0, '0);
      rset(0, 0, 1, 1, 11'h003, 8'h01);
      @(negedge clk);
      chk("R6 no data on conflict", {7'd0, r_rvalid}, 8'h00);
      rset(1, 0, 0, 1, 11'h003, 8'h00);
      @(negedge clk);
      chk("R6 token 3 still held", r_rdata, 8'h00);
      rset(1, 1, 0, 0, '0, '0);

      // R4 half build aliases the top address bit
      hset(0, 1, 1, 0, 11'h005, 8'h77);
      @(negedge clk);
      hset(0, 1, 1, 0, 11'h305, 8'h33);
      @(negedge clk);
      hset(0, 1, 0, 1, 11'h405, 8'h00);
      @(negedge clk);
      chk("R4 alias 0x405 -> 0x005", h_rdata, 8'h77);
      hset(0, 1, 0, 1, 11'h705, 8'h00);
      @(negedge clk);
      chk("R4 alias 0x705 -> 0x305", h_rdata, 8'h33);
      hset(0, 1, 0, 1, 11'h005, 8'h00);
      @(negedge clk);
      chk("R3 half banks independent", h_rdata, 8'h77);
      hset(1, 1, 0, 0, '0, '0);
      @(negedge clk);
      chk("R7 half idle bus zero", h_rdata, 8'h00);

      finish_run();
   end
endmodule